// File: doc/BRIEF.md
# Prescaler and Watchdog Timer

This block divides the system clock through a free-running binary prescaler and brings out two periodic single-cycle ticks: a fast tick every 1024 clocks and a slow tick every 16384 clocks. The fast tick feeds the interrupt logic as the divider event. The slow tick is available to any consumer that needs a longer period.

A small watchdog counter advances once for each tick from one of the two taps. A select bit chooses the tap. Software must clear the watchdog before it runs past its last count. If the watchdog wraps while enabled, the block emits a one-cycle reset request.

A separate strobe zeroes only the lowest prescaler stages. Software uses it to align the divider phase without disturbing the long-period count. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `clkdiv_wdt`

## Requirements
- R1: While `rst_n` is low, all three outputs are 0 and the prescaler and watchdog counts are held at zero. Counting starts on the third rising clock edge after `rst_n` rises, because internal release takes two edges.
- R2: `tick_fast` is high for exactly one cycle each time prescaler bit 9 falls, which is every 1024 clocks when there is no clear. It is high in the cycle that follows the edge where the low 10 prescaler bits wrap to zero.
- R3: `tick_slow` is high for exactly one cycle each time prescaler bit 13 falls, which is every 16384 clocks when there is no clear. Its timing relative to the wrap edge is the same as for `tick_fast`.
- R4: On an edge where `pre_clr` is 1, prescaler bits 3..0 become 0 and bits 13..4 keep their value. No carry passes upward, so the following ticks are delayed by the discarded count.
- R5: With `wdt_slow_sel` = 0 the watchdog advances on each `tick_fast`. With `wdt_slow_sel` = 1 it advances on each `tick_slow`.
- R6: On an edge where `wdt_clr` is 1, the watchdog count becomes 0. This holds even when a selected tick arrives on that same edge, and in that case no pulse appears on `wdt_fire`.
- R7: When the 4-bit watchdog advances from 15 to 0 while `wdt_en` is 1, `wdt_fire` is high for exactly the one cycle that follows that edge.
- R8: When `wdt_en` is 0, a 15-to-0 wrap raises no `wdt_fire`, and the watchdog still keeps counting.
- R9: A `pre_clr` on the edge where the low 10 prescaler bits would wrap suppresses that `tick_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_clr | input | 1 | Zero the low 4 prescaler bits |
| wdt_clr | input | 1 | Zero the watchdog count |
| wdt_en | input | 1 | Allow the watchdog to request reset |
| wdt_slow_sel | input | 1 | Watchdog tap select, 0 fast / 1 slow |
| tick_fast | output | 1 | Fast divider tick, interrupt event |
| tick_slow | output | 1 | Slow divider tick |
| wdt_fire | output | 1 | One-cycle watchdog reset request |

## Verification
Two coincidences matter.

The first is a watchdog clear that lands on the same edge as the selected tick that would wrap the count from 15. The second is a prescaler clear that lands on the edge where the fast tap would carry. The bench tracks a cycle model of both counters so that it can drive each strobe at exactly those edges.

It then expects that no reset pulse and no tick appear in the following cycle, and it confirms that later ticks shift by the discarded count. Random rare strobes across several phases of tap selection and enable cover the remaining interleavings.

// File: rtl/clkdiv_wdt_pkg.sv
package clkdiv_wdt_pkg;
  localparam int FAST_LOG2_DEF = 10;
  localparam int SLOW_LOG2_DEF = 14;
  localparam int CLR_BITS_DEF  = 4;
  localparam int WDT_W_DEF     = 4;
  localparam int NUM_TAPS      = 2;

  typedef enum logic {
    TAP_FAST = 1'b0,
    TAP_SLOW = 1'b1
  } tap_sel_e;
endpackage

// File: rtl/cdw_rst_sync.sv
module cdw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cdw_prescaler.sv
module cdw_prescaler
  import clkdiv_wdt_pkg::*;
#(
  parameter int FAST_LOG2 = FAST_LOG2_DEF,
  parameter int SLOW_LOG2 = SLOW_LOG2_DEF,
  parameter int CLR_BITS  = CLR_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_low,
  output logic [NUM_TAPS-1:0] ticks
);
  localparam int PRE_W = SLOW_LOG2;
  localparam int TAP_POS [NUM_TAPS] = '{FAST_LOG2, SLOW_LOG2};

  logic [PRE_W-1:0] cnt_q, cnt_d;

  // next state: free-running count, or low stages zeroed with no carry
  always_comb begin
    if (clr_low) cnt_d = {cnt_q[PRE_W-1:CLR_BITS], {CLR_BITS{1'b0}}};
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    logic tk_d, tk_q;
    // a tap falls when every stage below it carries
    always_comb tk_d = !clr_low && (&cnt_q[TAP_POS[g]-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tk_q <= 1'b0;
      else        tk_q <= tk_d;
    end
    assign ticks[g] = tk_q;

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tk_q |=> !tk_q);
  end

  // R4
  low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_low |=> (cnt_q[CLR_BITS-1:0] == '0) && $stable(cnt_q[PRE_W-1:CLR_BITS]));
endmodule

// File: rtl/cdw_watchdog.sv
module cdw_watchdog
  import clkdiv_wdt_pkg::*;
#(
  parameter int WDT_W = WDT_W_DEF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_fast,
  input  logic     tick_slow,
  input  tap_sel_e sel,
  input  logic     clr,
  input  logic     en,
  output logic     fire
);
  logic [WDT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             inc;
  logic             fire_d, fire_q;

  always_comb begin
    inc    = (sel == TAP_SLOW) ? tick_slow : tick_fast;
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    fire_d = en && inc && !clr && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_d;
  end

  assign fire = fire_q;

  // R6
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !fire_q);
  // R7
  wdt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == '0) && ($past(cnt_q) == {WDT_W{1'b1}}));
  // R8
  wdt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fire_q);
  // R7
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
endmodule

// File: rtl/clkdiv_wdt.sv
module clkdiv_wdt
  import clkdiv_wdt_pkg::*;
#(
  parameter int FAST_LOG2 = FAST_LOG2_DEF,
  parameter int SLOW_LOG2 = SLOW_LOG2_DEF,
  parameter int CLR_BITS  = CLR_BITS_DEF,
  parameter int WDT_W     = WDT_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_clr,
  input  logic wdt_clr,
  input  logic wdt_en,
  input  logic wdt_slow_sel,
  output logic tick_fast,
  output logic tick_slow,
  output logic wdt_fire
);
  logic                rst_int_n;
  logic [NUM_TAPS-1:0] ticks;
  tap_sel_e            sel;

  assign sel = tap_sel_e'(wdt_slow_sel);

  cdw_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cdw_prescaler #(
    .FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2), .CLR_BITS(CLR_BITS)
  ) u_pre (
    .clk(clk), .rst_n(rst_int_n), .clr_low(pre_clr), .ticks(ticks)
  );

  assign tick_fast = ticks[0];
  assign tick_slow = ticks[1];

  cdw_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_int_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .sel(sel), .clr(wdt_clr), .en(wdt_en), .fire(wdt_fire)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> !tick_fast && !tick_slow && !wdt_fire);
endmodule

// File: tb/tb_clkdiv_wdt.sv
`timescale 1ns/1ps
module tb_clkdiv_wdt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_clr = 1'b0, wdt_clr = 1'b0, wdt_en = 1'b0, wdt_slow_sel = 1'b0;
  logic tick_fast, tick_slow, wdt_fire;

  always #5 clk = ~clk;

  clkdiv_wdt dut (
    .clk(clk), .rst_n(rst_n), .pre_clr(pre_clr), .wdt_clr(wdt_clr),
    .wdt_en(wdt_en), .wdt_slow_sel(wdt_slow_sel),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .wdt_fire(wdt_fire)
  );

  int checks = 0, bad = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  logic [13:0] m_pre;
  logic [3:0]  m_wdt;
  logic        m_tf, m_ts, m_fire, m_inc;
  int          stage;

  function automatic logic [13:0] pre_next(logic [13:0] p, logic c);
    return c ? {p[13:4], 4'h0} : p + 14'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= '0; m_wdt <= '0; m_tf <= 0; m_ts <= 0; m_fire <= 0; stage <= 0;
    end else if (stage < 2) begin
      stage <= stage + 1;
    end else begin
      m_inc = wdt_slow_sel ? m_ts : m_tf;
      m_tf   <= !pre_clr && (&m_pre[9:0]);
      m_ts   <= !pre_clr && (&m_pre);
      m_pre  <= pre_next(m_pre, pre_clr);
      m_fire <= wdt_en && m_inc && !wdt_clr && (m_wdt == 4'hF);
      m_wdt  <= wdt_clr ? 4'h0 : (m_inc ? m_wdt + 4'h1 : m_wdt);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  bit   clr_since_fast = 0, clr_since_slow = 0;
  bit   coinc_wdt = 0, coinc_pre = 0;
  int   fires = 0;
  string fire_tag = "R7";

  task automatic compare_outputs();
    check(tick_fast === m_tf, clr_since_fast ? "R4 tick_fast" : "R2 tick_fast",
          int'(tick_fast), int'(m_tf));
    check(tick_slow === m_ts, clr_since_slow ? "R4 tick_slow" : "R3 tick_slow",
          int'(tick_slow), int'(m_ts));
    check(wdt_fire === m_fire, fire_tag, int'(wdt_fire), int'(m_fire));
    if (wdt_fire) fires++;
    if (m_tf) clr_since_fast = 0;
    if (m_ts) clr_since_slow = 0;
  endtask

  task automatic run(input int n, input int pclr_rate, input int wclr_rate,
                     input bit want_wdt_coinc, input bit want_pre_coinc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_outputs();
      pre_clr = (pclr_rate > 0) && ($urandom % pclr_rate == 0);
      wdt_clr = (wclr_rate > 0) && ($urandom % wclr_rate == 0);
      if (want_wdt_coinc && !coinc_wdt && m_wdt == 4'hF &&
          (wdt_slow_sel ? m_ts : m_tf)) begin
        wdt_clr = 1'b1; coinc_wdt = 1; fire_tag = "R6";
      end
      if (want_pre_coinc && !coinc_pre && (&m_pre[9:0])) begin
        pre_clr = 1'b1; coinc_pre = 1;
      end
      if (pre_clr) begin clr_since_fast = 1; clr_since_slow = 1; end
    end
    @(negedge clk);
    compare_outputs();
    pre_clr = 0; wdt_clr = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: quiet outputs while reset is held
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!tick_fast && !tick_slow && !wdt_fire, "R1 reset outputs",
            int'({tick_fast, tick_slow, wdt_fire}), 0);
    end
    rst_n = 1'b1;
    // R1, R2: first fast tick follows the 1024th counting edge
    wdt_en = 1; wdt_slow_sel = 0;
    for (int i = 0; i < 1026; i++) begin
      @(negedge clk);
      compare_outputs();
    end
    check(tick_fast === 1'b1, "R1 first tick timing", int'(tick_fast), 1);
    // R7: fast tap, enabled, rare prescaler clears
    fire_tag = "R7"; fires = 0;
    run(20000, 3000, 0, 0, 0);
    check(fires > 0, "R7 wrap pulses seen", fires, 1);
    // R8: disabled, no pulse though the count keeps wrapping
    wdt_en = 0; fire_tag = "R8"; fires = 0;
    run(20000, 0, 0, 0, 0);
    check(fires == 0, "R8 no pulse when disabled", fires, 0);
    // R5: slow tap with rare watchdog clears
    wdt_en = 1; wdt_slow_sel = 1; fire_tag = "R5";
    run(34000, 4000, 9000, 0, 0);
    // R6: clear on the same edge as the wrapping tick
    wdt_slow_sel = 0; fire_tag = "R7";
    run(20000, 0, 0, 1, 0);
    check(coinc_wdt, "R6 coincident clear provoked", int'(coinc_wdt), 1);
    // R9: prescaler clear on the carry edge of the fast tap
    fire_tag = "R7";
    run(3000, 0, 0, 0, 1);
    check(coinc_pre, "R9 coincident prescaler clear provoked", int'(coinc_pre), 1);
    run(2000, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule